// File: doc/BRIEF.md
# Request-Path Register Slice

This block is a pipeline stage placed between a manager and a subordinate on a valid/ready bus whose responses come back a fixed number of periods after each transfer. It registers the whole request set: write enable, address, byte enables, write data and the three command bits. Long combinational paths, such as those through address decoders, then end at a flop. The response set (read data and error flag) passes straight from the downstream side to the upstream side with no register.

The stage is a two-entry skid buffer. Upstream ready comes straight from a flop, so it never depends combinationally on downstream ready. The stage still accepts one request per period while the downstream side keeps up. When the downstream side stalls, up to two requests are held and none is lost.

A manager that sees this stage observes a response delay one period longer than the downstream segment's delay, as long as the request is not held by downstream backpressure. Each period a request waits in the stage adds one period. Only the two occupancy flags are reset. The payload registers have no reset and change only when a request is accepted or moved from the skid entry to the output entry.

Top module: `bus_req_slice`

## Requirements
- R1: While reset is high, `dn_vld` is 0 and `up_rdy` is 1.
- R2: `up_rdt` and `up_err` equal `dn_rdt` and `dn_err` in the same period, with no register between them.
- R3: Each request accepted upstream (`up_vld` and `up_rdy` high at a rising edge) is offered downstream exactly once, in acceptance order, with `wen`, `adr`, `ben`, `wdt` and `cmd` unchanged. `cmd` bit 2 is lock, bit 1 is repeat-address and bit 0 is incrementing-address.
- R4: While `dn_rdy` stays 1, `up_rdy` stays 1 and one request per period is accepted back-to-back.
- R5: While `dn_vld` is 1 and `dn_rdy` is 0, `dn_vld` and every downstream payload output keep their values into the next period.
- R6: `up_rdy` is driven from a register. When downstream stalls starting from an empty stage, exactly two requests are accepted before `up_rdy` goes to 0. `up_rdy` returns to 1 in the period after downstream accepts a request.
- R7: With `dn_rdy` held at 1, the response to a request appears upstream one period later than the downstream segment's delay, counted from the upstream transfer.
- R8: When no upstream transfer occurs and the skid entry is empty, the downstream payload outputs keep their previous values. Changes on the upstream payload inputs while `up_vld` is 0 have no effect on them.
- R9: `dn_vld` is 0 in the first period after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_vld | input | 1 | Request valid from the manager |
| up_rdy | output | 1 | Ready to the manager (registered) |
| up_wen | input | 1 | Write enable, 1 for a write |
| up_adr | input | ADR_W | Request address |
| up_ben | input | DAT_W/SEL_W | Byte enables |
| up_wdt | input | DAT_W | Write data |
| up_cmd | input | 3 | Command bits: [2] lock, [1] repeat, [0] increment |
| up_rdt | output | DAT_W | Read data to the manager |
| up_err | output | 1 | Error flag to the manager |
| dn_vld | output | 1 | Registered request valid to the subordinate |
| dn_rdy | input | 1 | Ready from the subordinate |
| dn_wen | output | 1 | Registered write enable |
| dn_adr | output | ADR_W | Registered address |
| dn_ben | output | DAT_W/SEL_W | Registered byte enables |
| dn_wdt | output | DAT_W | Registered write data |
| dn_cmd | output | 3 | Registered command bits |
| dn_rdt | input | DAT_W | Read data from the subordinate |
| dn_err | input | 1 | Error flag from the subordinate |

## Verification
The assertions check on every cycle the properties that depend only on the handshakes. They track an occupancy count taken from the port handshakes and check that it never exceeds two and that it agrees with `dn_vld`. They also check that `up_rdy` is high whenever a slot is free, that it recovers after a downstream accept, that a stalled request holds steady, that the stage is quiet in and just after reset, and that an idle period leaves the payload alone. Other behaviours need the bench's scenarios: the order and content of requests under steady, alternating and pseudo-random backpressure, the exact two-entry capacity, the response latency one period above the downstream delay, and the combinational pass-through of read data and error.

// File: rtl/brs_pkg.sv
package brs_pkg;
  // command field layout: [2] lock, [1] repeat address, [0] incrementing address
  localparam int unsigned CMD_W = 3;

  function automatic int unsigned lane_count(int unsigned dat_w, int unsigned sel_w);
    return dat_w / sel_w;
  endfunction
endpackage

// File: rtl/brs_ctrl.sv
module brs_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic up_vld,
  input  logic dn_rdy,
  output logic up_rdy,
  output logic dn_vld,
  output logic main_ld,
  output logic main_from_skid,
  output logic skid_ld
);
  logic main_full, skid_full;
  logic up_xfer, dn_xfer;

  assign up_xfer = up_vld & ~skid_full;
  assign dn_xfer = main_full & dn_rdy;

  // output entry refills when it is empty or is being consumed
  assign main_from_skid = skid_full;
  assign main_ld  = (~main_full | dn_xfer) & (skid_full | up_xfer);
  assign skid_ld  = up_xfer & main_full & ~dn_xfer;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_full <= 1'b0;
      skid_full <= 1'b0;
    end else begin
      main_full <= skid_full | up_xfer | (main_full & ~dn_xfer);
      skid_full <= skid_full ? ~dn_xfer : skid_ld;
    end
  end

  assign up_rdy = ~skid_full;
  assign dn_vld = main_full;
endmodule

// File: rtl/brs_hold_reg.sv
module brs_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // payload register without reset: keeps its value unless loaded
  always_ff @(posedge clk) begin
    if (ld) q <= d;
  end
endmodule

// File: rtl/bus_req_slice.sv
module bus_req_slice
  import brs_pkg::*;
#(
  parameter int unsigned ADR_W = 32,
  parameter int unsigned DAT_W = 32,
  parameter int unsigned SEL_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             up_vld,
  output logic                             up_rdy,
  input  logic                             up_wen,
  input  logic [ADR_W-1:0]                 up_adr,
  input  logic [lane_count(DAT_W,SEL_W)-1:0] up_ben,
  input  logic [DAT_W-1:0]                 up_wdt,
  input  logic [CMD_W-1:0]                 up_cmd,
  output logic [DAT_W-1:0]                 up_rdt,
  output logic                             up_err,
  output logic                             dn_vld,
  input  logic                             dn_rdy,
  output logic                             dn_wen,
  output logic [ADR_W-1:0]                 dn_adr,
  output logic [lane_count(DAT_W,SEL_W)-1:0] dn_ben,
  output logic [DAT_W-1:0]                 dn_wdt,
  output logic [CMD_W-1:0]                 dn_cmd,
  input  logic [DAT_W-1:0]                 dn_rdt,
  input  logic                             dn_err
);
  localparam int unsigned BEN_W = lane_count(DAT_W, SEL_W);
  localparam int unsigned PAY_W = CMD_W + 1 + BEN_W + ADR_W + DAT_W;
  localparam int unsigned NSTG  = 2;  // entry 0 drives downstream, entry 1 is the skid

  logic [PAY_W-1:0]            up_pay;
  logic [NSTG-1:0][PAY_W-1:0]  st_d, st_q;
  logic [NSTG-1:0]             st_ld;
  logic                        main_from_skid;

  assign up_pay = {up_cmd, up_wen, up_ben, up_adr, up_wdt};

  brs_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .up_vld         (up_vld),
    .dn_rdy         (dn_rdy),
    .up_rdy         (up_rdy),
    .dn_vld         (dn_vld),
    .main_ld        (st_ld[0]),
    .main_from_skid (main_from_skid),
    .skid_ld        (st_ld[1])
  );

  assign st_d[0] = main_from_skid ? st_q[1] : up_pay;
  assign st_d[1] = up_pay;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    brs_hold_reg #(.W(PAY_W)) u_reg (
      .clk (clk),
      .ld  (st_ld[s]),
      .d   (st_d[s]),
      .q   (st_q[s])
    );
  end

  assign {dn_cmd, dn_wen, dn_ben, dn_adr, dn_wdt} = st_q[0];

  // response set is not registered
  assign up_rdt = dn_rdt;
  assign up_err = dn_err;
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int unsigned ADR_W = 32,
  parameter int unsigned DAT_W = 32,
  parameter int unsigned SEL_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     up_vld,
  input logic                     up_rdy,
  input logic                     dn_vld,
  input logic                     dn_rdy,
  input logic                     dn_wen,
  input logic [ADR_W-1:0]         dn_adr,
  input logic [DAT_W/SEL_W-1:0]   dn_ben,
  input logic [DAT_W-1:0]         dn_wdt,
  input logic [2:0]               dn_cmd
);
  logic [1:0] occ;
  logic       up_x, dn_x;

  assign up_x = up_vld & up_rdy;
  assign dn_x = dn_vld & dn_rdy;

  always_ff @(posedge clk) begin
    if (rst) occ <= 2'd0;
    else     occ <= 2'(occ + {1'b0, up_x} - {1'b0, dn_x});
  end

  AST_RST_STATE: assert property (@(posedge clk) $past(rst) && rst |-> !dn_vld && up_rdy); // R1
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst) occ <= 2'd2 && (dn_vld == (occ != 2'd0))); // R3
  AST_READY_FREE: assert property (@(posedge clk) disable iff (rst) occ < 2'd2 |-> up_rdy); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    dn_vld && !dn_rdy |=> dn_vld && $stable(dn_adr) && $stable(dn_wdt) && $stable(dn_ben)
                          && $stable(dn_wen) && $stable(dn_cmd)); // R5
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (rst) !up_rdy && !dn_rdy |=> !up_rdy); // R6
  AST_RDY_RECOVER: assert property (@(posedge clk) disable iff (rst) !up_rdy && dn_x |=> up_rdy); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    up_rdy && !up_vld |=> $stable(dn_adr) && $stable(dn_wdt) && $stable(dn_ben)
                          && $stable(dn_wen) && $stable(dn_cmd)); // R8
  AST_POST_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !dn_vld); // R9
endmodule

bind bus_req_slice brs_checker #(.ADR_W(ADR_W), .DAT_W(DAT_W), .SEL_W(SEL_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .up_vld (up_vld),
  .up_rdy (up_rdy),
  .dn_vld (dn_vld),
  .dn_rdy (dn_rdy),
  .dn_wen (dn_wen),
  .dn_adr (dn_adr),
  .dn_ben (dn_ben),
  .dn_wdt (dn_wdt),
  .dn_cmd (dn_cmd)
);

// File: tb/sim_bus_req_slice.sv
module sim_bus_req_slice;
  localparam time HALF   = 10ns;  // 50 MHz
  localparam int  ADR_W  = 32;
  localparam int  DAT_W  = 32;
  localparam int  BEN_W  = 4;
  localparam int  DN_DLY = 1;     // delay of the bench subordinate
  localparam int  UP_DLY = DN_DLY + 1;

  typedef struct packed {
    logic [2:0]       cmd;
    logic             wen;
    logic [BEN_W-1:0] ben;
    logic [ADR_W-1:0] adr;
    logic [DAT_W-1:0] wdt;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_vld = 1'b0, up_rdy, up_wen = 1'b0, up_err;
  logic [ADR_W-1:0] up_adr = '0;
  logic [BEN_W-1:0] up_ben = '0;
  logic [DAT_W-1:0] up_wdt = '0, up_rdt;
  logic [2:0] up_cmd = '0;
  logic dn_vld, dn_rdy = 1'b0, dn_wen, dn_err;
  logic [ADR_W-1:0] dn_adr;
  logic [BEN_W-1:0] dn_ben;
  logic [DAT_W-1:0] dn_wdt, dn_rdt;
  logic [2:0] dn_cmd;

  logic [DAT_W-1:0] sub_rdt = '0, frc_rdt = '0;
  logic sub_err = 1'b0, frc_err = 1'b0, rsp_force = 1'b0;
  int   rdy_mode = 0;
  int   n_chk = 0, n_fail = 0;
  int   cyc = 0;
  logic hold_flag = 1'b0;
  item_t hold_it;
  item_t sb[$];

  bus_req_slice #(.ADR_W(ADR_W), .DAT_W(DAT_W), .SEL_W(8)) u0 (
    .clk(clk), .rst(rst),
    .up_vld(up_vld), .up_rdy(up_rdy), .up_wen(up_wen), .up_adr(up_adr), .up_ben(up_ben),
    .up_wdt(up_wdt), .up_cmd(up_cmd), .up_rdt(up_rdt), .up_err(up_err),
    .dn_vld(dn_vld), .dn_rdy(dn_rdy), .dn_wen(dn_wen), .dn_adr(dn_adr), .dn_ben(dn_ben),
    .dn_wdt(dn_wdt), .dn_cmd(dn_cmd), .dn_rdt(dn_rdt), .dn_err(dn_err)
  );

  always #(HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign dn_rdt = rsp_force ? frc_rdt : sub_rdt;
  assign dn_err = rsp_force ? frc_err : sub_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic item_t mk(input int i, input logic [ADR_W-1:0] base);
    item_t it;
    it.adr = base + ADR_W'(i * 4);
    it.wen = i[0];
    it.ben = (i[2]) ? 4'hF : (4'b0001 << (i % 4));
    it.wdt = {i[15:0], base[15:0]} ^ 32'h5A3C_0F11;
    it.cmd = 3'(i);
    return it;
  endfunction

  function automatic item_t dn_item();
    item_t it;
    it.cmd = dn_cmd; it.wen = dn_wen; it.ben = dn_ben; it.adr = dn_adr; it.wdt = dn_wdt;
    return it;
  endfunction

  task automatic apply(input item_t it);
    up_cmd = it.cmd; up_wen = it.wen; up_ben = it.ben; up_adr = it.adr; up_wdt = it.wdt;
  endtask

  // driver: called just after a rising edge; returns just after the accepting edge
  task automatic put(input item_t it);
    up_vld = 1'b1;
    apply(it);
    do @(negedge clk); while (!up_rdy);
    sb.push_back(it);
    @(posedge clk); #(1ns);
    up_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    up_vld = 1'b0;
    for (int k = 0; k < n; k++) begin
      apply(mk(k + 77, 32'hDEAD_0000));
      @(posedge clk); #(1ns);
    end
  endtask

  task automatic drain(input string req);
    rdy_mode = 0;
    for (int k = 0; k < 60 && (sb.size() != 0 || dn_vld); k++) begin
      @(posedge clk); #(1ns);
    end
    chk(sb.size() == 0, req, "queue empty after drain", 128'(sb.size()), 128'd0);
  endtask

  // downstream ready patterns
  always begin : rdy_drv
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    forever begin
      @(posedge clk); #(2ns);
      case (rdy_mode)
        0: dn_rdy = 1'b1;
        1: dn_rdy = 1'b0;
        2: dn_rdy = ~dn_rdy;
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          dn_rdy = lfsr[0] | lfsr[3];
        end
      endcase
    end
  end

  // subordinate with a one-period response delay
  always begin : sub_model
    logic cap;
    logic [ADR_W-1:0] cap_adr;
    @(negedge clk);
    cap = dn_vld && dn_rdy && !rst;
    cap_adr = dn_adr;
    @(posedge clk); #(1ns);
    sub_rdt = cap ? ~cap_adr : '0;
    sub_err = cap ? cap_adr[2] : 1'b0;
  end

  // monitor: pops expected requests and checks hold behaviour
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_flag) begin
        chk(dn_vld && dn_item() == hold_it, "R5", "held request stable",
            128'(dn_item()), 128'(hold_it));
      end
      hold_flag = dn_vld && !dn_rdy;
      hold_it   = dn_item();
      if (dn_vld && dn_rdy) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R3", "unexpected downstream transfer", 128'(dn_item()), 128'd0);
        end else begin
          item_t e;
          e = sb.pop_front();
          chk(dn_item() == e, "R3", "downstream request content/order",
              128'(dn_item()), 128'(e));
        end
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin : watchdog
    #(HALF * 2 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dn_vld == 1'b0, "R1", "dn_vld in reset", 128'(dn_vld), 128'd0);
    chk(up_rdy == 1'b1, "R1", "up_rdy in reset", 128'(up_rdy), 128'd1);
    @(posedge clk); #(1ns);
    rst = 1'b0;
    @(negedge clk);
    chk(dn_vld == 1'b0, "R9", "dn_vld first period after reset", 128'(dn_vld), 128'd0);

    // R2: combinational response pass-through
    rsp_force = 1'b1; frc_rdt = 32'hCAFE_F00D; frc_err = 1'b1;
    #(1ns);
    chk(up_rdt == 32'hCAFE_F00D && up_err == 1'b1, "R2", "response pass-through a",
        128'({up_err, up_rdt}), 128'({1'b1, 32'hCAFE_F00D}));
    frc_rdt = 32'h0123_4567; frc_err = 1'b0;
    #(1ns);
    chk(up_rdt == 32'h0123_4567 && up_err == 1'b0, "R2", "response pass-through b",
        128'({up_err, up_rdt}), 128'({1'b0, 32'h0123_4567}));
    rsp_force = 1'b0;
    @(posedge clk); #(1ns);
    idle(3);

    // R7: latency one period above the downstream delay
    begin
      item_t a;
      a = mk(2, 32'h0000_1000);  // read, adr 0x1008
      put(a);
      @(negedge clk);
      chk(up_rdt == '0, "R7", "no response before delay", 128'(up_rdt), 128'd0);
      repeat (UP_DLY - 1) @(negedge clk);
      chk(up_rdt == ~a.adr && up_err == a.adr[2], "R7", "response at upstream delay",
          128'({up_err, up_rdt}), 128'({a.adr[2], ~a.adr}));
      @(posedge clk); #(1ns);
    end
    drain("R7");

    // R4: back-to-back throughput with no backpressure
    begin
      int t0;
      t0 = cyc;
      for (int i = 0; i < 16; i++) put(mk(i, 32'h0001_0000));
      chk(cyc - t0 == 16, "R4", "periods for 16 requests", 128'(cyc - t0), 128'd16);
    end
    drain("R4");

    // R3: alternating and pseudo-random backpressure
    rdy_mode = 2;
    for (int i = 0; i < 20; i++) put(mk(i, 32'h0002_0000));
    drain("R3");
    rdy_mode = 3;
    for (int i = 0; i < 40; i++) put(mk(i, 32'h0003_0000));
    drain("R3");
    idle(2);

    // R6: capacity of two under stall, then recovery
    begin
      int acc, idx;
      rdy_mode = 1;
      @(posedge clk); #(1ns);
      acc = 0; idx = 0;
      up_vld = 1'b1;
      apply(mk(idx, 32'h0004_0000));
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (up_rdy) begin
          sb.push_back(mk(idx, 32'h0004_0000));
          acc++; idx++;
        end
        @(posedge clk); #(1ns);
        apply(mk(idx, 32'h0004_0000));
      end
      chk(acc == 2, "R6", "requests accepted while stalled", 128'(acc), 128'd2);
      @(negedge clk);
      chk(up_rdy == 1'b0, "R6", "up_rdy low when full", 128'(up_rdy), 128'd0);
      @(posedge clk); #(1ns);
      rdy_mode = 0;
      @(negedge clk);
      chk(up_rdy == 1'b0, "R6", "up_rdy still low before downstream accept", 128'(up_rdy), 128'd0);
      @(negedge clk);
      chk(up_rdy == 1'b1, "R6", "up_rdy back after downstream accept", 128'(up_rdy), 128'd1);
      sb.push_back(mk(idx, 32'h0004_0000));
      @(posedge clk); #(1ns);
      up_vld = 1'b0;
    end
    drain("R6");

    // R8: payload outputs ignore upstream inputs while idle
    begin
      item_t snap;
      @(negedge clk);
      snap = dn_item();
      @(posedge clk); #(1ns);
      idle(5);
      @(negedge clk);
      chk(dn_item() == snap, "R8", "payload unchanged while idle", 128'(dn_item()), 128'(snap));
      chk(dn_vld == 1'b0, "R8", "dn_vld low while idle", 128'(dn_vld), 128'd0);
    end

    summary();
    $finish;
  end
endmodule